// File: doc/BRIEF.md
# Floating-Point Operation Issue Sequencer

This block takes one floating-point instruction byte and runs the strobe sequence that drives an external pair of arithmetic chips: an ALU chip and a multiplier chip. The byte is decoded into an operation class. The class fixes three things: the number of operand words to be loaded, the number of result words to be returned, and the execution time in cycles. The block then steps through a load phase, a fixed wait and an unload phase. Throughout the operation it presents the low six bits of the byte as the function code that both chips see.

Each unit has its own load select and its own unload select. A set-mode byte selects both units at load time and returns nothing. A comparison returns only status, so it raises no unload select. A cancel input reports a reject or fault on the instruction before this one; when it is high, the byte is dropped and no load select is raised. A busy flag covers the whole sequence. A byte that addresses neither unit is illegal and raises a one-cycle error pulse.

Top module: `fp_issue_seq`

## Requirements
- R1: A byte is accepted when `op_valid` is high and `busy` is low at a rising clock edge, and `cancel` is low. In the cycle after acceptance, the load selects are raised for one cycle according to bits 7 and 6 of the byte. Bits 7:6 = 10 raises `ld_cs_mul`. Bits 7:6 = 01 raises `ld_cs_alu`. Bits 7:6 = 11 is set-mode and raises both.
- R2: An accepted byte with bits 7:6 = 00 is illegal. It raises `ill_err` for exactly one cycle, in the cycle after acceptance. It raises no select and leaves `busy` low.
- R3: The execution length N is counted from the load-select cycle. N is 2 for set-mode, 3 for ALU operations and 3 for single-precision multiplies, and 4 for double-precision multiplies. Precision is taken from function bit 0 (bit 0 = 1 means double). Where an unload select is raised, it is raised for one cycle, N cycles after the load-select cycle.
- R4: While busy, `opnd_words` and `res_words` show the word counts of the operation. A single word is 1 and a double word is 2. For ALU bytes, function bits 5:4 give the kind: 00 subtract, 01 add, 10 compare, 11 convert. Bit 3 = 1 marks a one-operand form of subtract, add and compare. Operand words are one or two operands times the word size. Subtract and add return one result of the operand size. A convert takes one operand and returns one word of the other size. A multiply takes two operands and returns one result. Set-mode and compare have zero result words, and set-mode has zero operand words.
- R5: Compare and set-mode operations raise no unload select. ALU operations that return a result raise `ul_cs_alu`, and multiplies raise `ul_cs_mul`.
- R6: When `cancel` is high at the acceptance edge, the byte starts nothing. No load or unload select follows, `busy` stays low, and there is no error pulse, even for an illegal byte.
- R7: `busy` is high from the load-select cycle through the Nth cycle after it, and falls in the next cycle. A byte presented while `busy` is high is ignored; this holds for illegal bytes too.
- R8: While busy, `func_code` equals bits 5:0 of the accepted byte and holds steady. While idle it reads 0, and so do both word counts.
- R9: A load select and an unload select are never high in the same cycle.
- R10: While reset is high and directly after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction byte present |
| op_byte | input | 8 | Instruction byte: multiply select, ALU select, 6-bit function |
| cancel | input | 1 | Reject or fault on the preceding instruction |
| busy | output | 1 | Sequence in progress |
| ld_cs_alu | output | 1 | Load select, ALU chip |
| ld_cs_mul | output | 1 | Load select, multiplier chip |
| ul_cs_alu | output | 1 | Unload select, ALU chip |
| ul_cs_mul | output | 1 | Unload select, multiplier chip |
| func_code | output | 6 | Function code passed to the chips |
| opnd_words | output | 3 | Operand words of the current operation |
| res_words | output | 2 | Result words of the current operation |
| ill_err | output | 1 | One-cycle illegal-byte pulse |

## Verification
The bench targets the places where the class decode diverges. These are double- versus single-precision multiply length, one- versus two-operand ALU forms, converts that change size, and compares that must stay silent at unload time. A design that misreads function bit 0 or bit 3 would return wrong word counts or unload a cycle early or late. One that ignores the compare class would raise a stray unload select. The bench also cancels both a legal and an illegal byte, where a faulty design would still strobe or pulse an error. It presents bytes, illegal ones included, in the middle of a running sequence, where a faulty design would restart, corrupt the function code or flag a spurious error.

// File: rtl/fp_seq_pkg.sv
package fp_seq_pkg;

    localparam int FUNC_W  = 6;
    localparam int BYTE_W  = FUNC_W + 2;
    localparam int OPW_W   = 3;
    localparam int RESW_W  = 2;
    localparam int CYC_W   = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_WAIT = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        U_NONE = 2'd0,
        U_ALU  = 2'd1,
        U_MUL  = 2'd2,
        U_MODE = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        K_SUB  = 2'd0,
        K_ADD  = 2'd1,
        K_CMP  = 2'd2,
        K_CONV = 2'd3
    } alu_kind_e;

    typedef struct packed {
        unit_e               unit;
        logic [FUNC_W-1:0]   func;
        logic [OPW_W-1:0]    opnd_words;
        logic [RESW_W-1:0]   res_words;
        logic [CYC_W-1:0]    n_cyc;
        logic                has_result;
    } op_info_t;

    function automatic logic [OPW_W-1:0] size_words(input logic dbl);
        return dbl ? OPW_W'(2) : OPW_W'(1);
    endfunction

    function automatic logic [RESW_W-1:0] res_size(input logic dbl);
        return dbl ? RESW_W'(2) : RESW_W'(1);
    endfunction

endpackage

// File: rtl/fp_op_decode.sv
module fp_op_decode
    import fp_seq_pkg::*;
#(
    parameter int CYC_SET  = 2,
    parameter int CYC_STD  = 3,
    parameter int CYC_DMUL = 4
) (
    input  logic [BYTE_W-1:0] op_byte,
    output op_info_t          info
);

    logic              sel_mul;
    logic              sel_alu;
    logic [FUNC_W-1:0] fn;
    logic              dbl;
    logic              unary;
    alu_kind_e         kind;
    logic [OPW_W-1:0]  w_one;
    logic [OPW_W-1:0]  w_two;

    assign sel_mul = op_byte[BYTE_W-1];
    assign sel_alu = op_byte[BYTE_W-2];
    assign fn      = op_byte[FUNC_W-1:0];
    assign dbl     = fn[0];
    assign unary   = fn[3];
    assign kind    = alu_kind_e'(fn[5:4]);
    assign w_one   = size_words(dbl);
    assign w_two   = {w_one[OPW_W-2:0], 1'b0};

    always_comb begin
        info.unit       = U_NONE;
        info.func       = fn;
        info.opnd_words = '0;
        info.res_words  = '0;
        info.n_cyc      = '0;
        info.has_result = 1'b0;
        unique case ({sel_mul, sel_alu})
            2'b11: begin
                info.unit  = U_MODE;
                info.n_cyc = CYC_W'(CYC_SET);
            end
            2'b10: begin
                info.unit       = U_MUL;
                info.n_cyc      = dbl ? CYC_W'(CYC_DMUL) : CYC_W'(CYC_STD);
                info.opnd_words = w_two;
                info.res_words  = res_size(dbl);
                info.has_result = 1'b1;
            end
            2'b01: begin
                info.unit  = U_ALU;
                info.n_cyc = CYC_W'(CYC_STD);
                unique case (kind)
                    K_CONV: begin
                        info.opnd_words = w_one;
                        info.res_words  = res_size(!dbl);
                        info.has_result = 1'b1;
                    end
                    K_CMP: begin
                        info.opnd_words = unary ? w_one : w_two;
                    end
                    default: begin
                        info.opnd_words = unary ? w_one : w_two;
                        info.res_words  = res_size(dbl);
                        info.has_result = 1'b1;
                    end
                endcase
            end
            default: begin
                info.unit = U_NONE;
            end
        endcase
    end

endmodule

// File: rtl/fp_phase_ctrl.sv
module fp_phase_ctrl
    import fp_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CYC_W-1:0] n_cyc,
    output phase_e           phase
);

    logic [CYC_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            wait_cnt <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) phase <= PH_LOAD;
                end
                PH_LOAD: begin
                    wait_cnt <= n_cyc - CYC_W'(2);
                    phase    <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (wait_cnt == '0) phase <= PH_DONE;
                    else                wait_cnt <= wait_cnt - CYC_W'(1);
                end
                PH_DONE: begin
                    phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DONE) |=> (phase == PH_IDLE));

    // R3
    load_then_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD) |=> (phase == PH_WAIT));

endmodule

// File: rtl/fp_strobe_gen.sv
module fp_strobe_gen
    import fp_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_e phase,
    input  unit_e  unit,
    input  logic   has_result,
    output logic   ld_alu,
    output logic   ld_mul,
    output logic   ul_alu,
    output logic   ul_mul
);

    logic in_load;
    logic in_unload;

    assign in_load   = (phase == PH_LOAD);
    assign in_unload = (phase == PH_DONE) && has_result;

    always_comb begin
        ld_alu = in_load && (unit == U_ALU || unit == U_MODE);
        ld_mul = in_load && (unit == U_MUL || unit == U_MODE);
        ul_alu = in_unload && (unit == U_ALU);
        ul_mul = in_unload && (unit == U_MUL);
    end

    // R9
    no_bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
        !((ld_alu || ld_mul) && (ul_alu || ul_mul)));

    // R5
    mode_no_unload_chk: assert property (@(posedge clk) disable iff (rst)
        (unit == U_MODE) |-> !(ul_alu || ul_mul));

endmodule

// File: rtl/fp_issue_seq.sv
module fp_issue_seq
    import fp_seq_pkg::*;
#(
    parameter int CYC_SET  = 2,
    parameter int CYC_STD  = 3,
    parameter int CYC_DMUL = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [7:0]        op_byte,
    input  logic              cancel,
    output logic              busy,
    output logic              ld_cs_alu,
    output logic              ld_cs_mul,
    output logic              ul_cs_alu,
    output logic              ul_cs_mul,
    output logic [5:0]        func_code,
    output logic [2:0]        opnd_words,
    output logic [1:0]        res_words,
    output logic              ill_err
);

    op_info_t dec_info;
    op_info_t op_q;
    phase_e   phase;
    logic     accept;
    logic     start;
    logic     illegal;
    logic     err_q;

    fp_op_decode #(
        .CYC_SET  (CYC_SET),
        .CYC_STD  (CYC_STD),
        .CYC_DMUL (CYC_DMUL)
    ) decode_i (
        .op_byte (op_byte),
        .info    (dec_info)
    );

    assign accept  = op_valid && (phase == PH_IDLE) && !cancel;
    assign illegal = (dec_info.unit == U_NONE);
    assign start   = accept && !illegal;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= accept && illegal;
            if (start) op_q <= dec_info;
        end
    end

    fp_phase_ctrl phase_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .n_cyc (op_q.n_cyc),
        .phase (phase)
    );

    fp_strobe_gen strobe_i (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .unit       (op_q.unit),
        .has_result (op_q.has_result),
        .ld_alu     (ld_cs_alu),
        .ld_mul     (ld_cs_mul),
        .ul_alu     (ul_cs_alu),
        .ul_mul     (ul_cs_mul)
    );

    assign busy       = (phase != PH_IDLE);
    assign ill_err    = err_q;
    assign func_code  = busy ? op_q.func       : '0;
    assign opnd_words = busy ? op_q.opnd_words : '0;
    assign res_words  = busy ? op_q.res_words  : '0;

    // R2
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && !cancel && op_byte[7:6] == 2'b00) |=> (ill_err && !busy));

    // R6
    cancel_squash_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !busy && cancel) |=> (!busy && !ld_cs_alu && !ld_cs_mul && !ill_err));

    // R7
    busy_starts_load_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (ld_cs_alu || ld_cs_mul));

    // R8
    func_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(func_code));

    // R3
    unload_late_chk: assert property (@(posedge clk) disable iff (rst)
        (ul_cs_alu || ul_cs_mul) |-> $past(busy));

endmodule

// File: tb/fp_issue_seq_tb_top.sv
module fp_issue_seq_tb_top;

    typedef struct packed {
        logic       busy;
        logic       lda;
        logic       ldm;
        logic       ula;
        logic       ulm;
        logic       err;
        logic [5:0] fn;
        logic [2:0] opw;
        logic [1:0] resw;
    } obs_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic       cancel = 1'b0;
    logic       busy, ld_cs_alu, ld_cs_mul, ul_cs_alu, ul_cs_mul, ill_err;
    logic [5:0] func_code;
    logic [2:0] opnd_words;
    logic [1:0] res_words;

    int checks = 0;
    int errors = 0;
    obs_t exp_q[$];

    always #5 clk = ~clk;

    fp_issue_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .op_valid   (op_valid),
        .op_byte    (op_byte),
        .cancel     (cancel),
        .busy       (busy),
        .ld_cs_alu  (ld_cs_alu),
        .ld_cs_mul  (ld_cs_mul),
        .ul_cs_alu  (ul_cs_alu),
        .ul_cs_mul  (ul_cs_mul),
        .func_code  (func_code),
        .opnd_words (opnd_words),
        .res_words  (res_words),
        .ill_err    (ill_err)
    );

    function automatic obs_t sample();
        obs_t o;
        o.busy = busy;  o.lda = ld_cs_alu; o.ldm = ld_cs_mul;
        o.ula = ul_cs_alu; o.ulm = ul_cs_mul; o.err = ill_err;
        o.fn = func_code; o.opw = opnd_words; o.resw = res_words;
        return o;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic final_report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // monitor: pop one expected item per cycle, mid-cycle
    initial begin
        forever begin
            obs_t a, e;
            @(posedge clk);
            #3;
            a = sample();
            if (!rst) chk(!((a.lda || a.ldm) && (a.ula || a.ulm)), "R9 ld/ul overlap",
                          {a.lda, a.ldm, a.ula, a.ulm}, 0);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(a.busy == e.busy, "R7 busy", a.busy, e.busy);
                chk({a.lda, a.ldm} == {e.lda, e.ldm}, "R1/R6 load selects", {a.lda, a.ldm}, {e.lda, e.ldm});
                chk({a.ula, a.ulm} == {e.ula, e.ulm}, "R3/R5 unload selects", {a.ula, a.ulm}, {e.ula, e.ulm});
                chk(a.err == e.err, "R2 error pulse", a.err, e.err);
                chk(a.fn == e.fn, "R8 function code", a.fn, e.fn);
                chk({a.opw, a.resw} == {e.opw, e.resw}, "R4 word counts", {a.opw, a.resw}, {e.opw, e.resw});
            end
        end
    end

    // driver: pushes the expected cycle trace, then drives the byte
    task automatic issue(input logic [7:0] b, input bit cxl, input int intr_at, input logic [7:0] intr_b);
        obs_t z, e;
        int n;
        int len;
        logic mul, alu, dbl, un;
        logic [1:0] kind;
        logic [2:0] w, opw;
        logic [1:0] resw;
        bit has_ul;
        z = '0;
        mul = b[7]; alu = b[6]; dbl = b[0]; un = b[3]; kind = b[5:4];
        w = dbl ? 3'd2 : 3'd1;
        n = 0; opw = 0; resw = 0; has_ul = 0;
        if (mul && alu) begin
            n = 2;
        end else if (mul) begin
            n = dbl ? 4 : 3; opw = w * 2; resw = dbl ? 2'd2 : 2'd1; has_ul = 1;
        end else if (alu) begin
            n = 3;
            if (kind == 2'b11) begin
                opw = w; resw = dbl ? 2'd1 : 2'd2; has_ul = 1;
            end else if (kind == 2'b10) begin
                opw = un ? w : w * 2;
            end else begin
                opw = un ? w : w * 2; resw = dbl ? 2'd2 : 2'd1; has_ul = 1;
            end
        end
        @(negedge clk);
        op_valid = 1'b1; op_byte = b; cancel = cxl;
        if (cxl) begin
            exp_q.push_back(z); len = 1;
        end else if (!mul && !alu) begin
            e = z; e.err = 1'b1; exp_q.push_back(e); len = 1;
        end else begin
            for (int t = 1; t <= n + 1; t++) begin
                e = z; e.busy = 1'b1; e.fn = b[5:0]; e.opw = opw; e.resw = resw;
                if (t == 1) begin e.lda = alu; e.ldm = mul; end
                if (t == n + 1 && has_ul) begin e.ula = alu; e.ulm = mul; end
                exp_q.push_back(e);
            end
            exp_q.push_back(z);
            len = n + 2;
        end
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i == 1) begin op_valid = 1'b0; cancel = 1'b0; end
            if (i == intr_at) begin op_valid = 1'b1; op_byte = intr_b; end
            else if (i == intr_at + 1) op_valid = 1'b0;
        end
    endtask

    initial begin
        #(200_000 * 10);
        chk(0, "watchdog expired", 0, 1);
        final_report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        chk(sample() == '0, "R10 reset state", sample(), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(sample() == '0, "R10 after reset", sample(), 0);

        issue(8'h80, 0, 0, 8'h00); // R1 R3 single multiply, N=3
        issue(8'h81, 0, 0, 8'h00); // R3 double multiply, N=4
        issue(8'h93, 0, 0, 8'h00); // multiply, other function bits
        issue(8'h40, 0, 0, 8'h00); // ALU subtract single, binary
        issue(8'h51, 0, 0, 8'h00); // ALU add double, binary
        issue(8'h49, 0, 0, 8'h00); // R4 one-operand double
        issue(8'h60, 0, 0, 8'h00); // R5 compare, no unload
        issue(8'h69, 0, 0, 8'h00); // compare one-operand double
        issue(8'h70, 0, 0, 8'h00); // convert single to double
        issue(8'h71, 0, 0, 8'h00); // convert double to single
        issue(8'hC5, 0, 0, 8'h00); // set-mode, both loads, N=2
        issue(8'h25, 0, 0, 8'h00); // R2 illegal
        issue(8'h80, 1, 0, 8'h00); // R6 cancelled legal
        issue(8'h00, 1, 0, 8'h00); // R6 cancelled illegal, no error
        issue(8'h81, 0, 2, 8'h40); // R7 byte while busy ignored
        issue(8'h61, 0, 1, 8'h00); // R7 illegal while busy, no error
        issue(8'hC0, 0, 1, 8'h81); // set-mode with intruder
        issue(8'h4B, 0, 0, 8'h00);

        repeat (3) @(negedge clk);
        chk(sample() == '0, "R8 idle outputs", sample(), 0);
        final_report();
    end

endmodule